// File: doc/BRIEF.md
# Digital PLL Steering a Divide-by-4 to an 8 kHz Reference

This block runs on a 16.384 MHz system clock and produces a single-cycle enable that fires, on average, once every four system clocks (4.096 MHz). It also divides that enable further to produce a local 8 kHz frame tick, and it keeps the tick frequency-locked to an external 8 kHz reference. A mode input chooses one of three reference pins, or none at all.

Each rising edge of the selected reference is synchronised and then compared with the position of the local frame tick. If the reference arrives early, one divide cycle is shortened to three clocks. If it arrives late, one divide cycle is stretched to five clocks. A phase error within one system clock is left alone. No frame ever holds more than one corrected divide cycle, so the enable never moves by more than one system-clock period from the ideal grid. A lock flag summarises how quiet the loop is. When the reference goes missing, the divider falls back to an exact divide-by-4.

The block has no data stream. All pins are plain control and status signals with no handshake, and there is no back-pressure.

Top module: `dpll_8k`

## Requirements
- R1: While `rst_n` is low, `clk4_en`, `frame_tick` and `locked` are all low. After release, the first `clk4_en` pulse comes in the third clock after the first rising edge with `rst_n` high.
- R2: With no correction applied, `clk4_en` pulses every NOM_DIV (4) clocks and `frame_tick` pulses every FRAME_DIV enables, which is NOM_DIV*FRAME_DIV clocks.
- R3: `mode` selects the reference: 0 selects none, 1 selects `ref_a`, 2 selects `ref_b` and 3 selects `ref_c`. Pins that are not selected have no effect.
- R4: A correction changes exactly one divide cycle, to NOM_DIV-1 clocks (advance) or to NOM_DIV+1 clocks (retard). Every enable interval is 3, 4 or 5 clocks, and each frame holds at most one interval other than 4.
- R5: When the reference runs faster than the local frame, divide cycles are shortened, and in steady state every frame lasts FRAME_CLKS-1 clocks. When the reference runs slower, divide cycles are stretched, and every frame lasts FRAME_CLKS+1 clocks.
- R6: A reference edge that lands within DEAD_BAND (1) clock of the local tick causes no correction. Once converged on a reference whose period equals the frame, every enable interval is 4.
- R7: `locked` rises only on a `frame_tick`, and only after LOCK_FRAMES (16) consecutive frames with no correction.
- R8: `locked` falls after UNLOCK_RUN (4) consecutive frames that are each corrected in the same direction.
- R9: If no reference edge is seen for more than MISS_FRAMES (2) frame ticks, the reference counts as lost. Corrections are then frozen, so the divider runs at exactly divide-by-4, and `locked` is cleared. The first edge after a loss only re-arms the comparator.
- R10: Every `frame_tick` pulse coincides with a `clk4_en` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Reference select: 0 none, 1 `ref_a`, 2 `ref_b`, 3 `ref_c` |
| ref_a | input | 1 | 8 kHz reference candidate A, asynchronous |
| ref_b | input | 1 | 8 kHz reference candidate B, asynchronous |
| ref_c | input | 1 | 8 kHz reference candidate C, asynchronous |
| clk4_en | output | 1 | One-clock enable, nominally every 4 clocks |
| frame_tick | output | 1 | Local 8 kHz tick, one clock wide |
| locked | output | 1 | Loop is quiet and the reference is present |

## Verification
The assertions assume a reference that changes no faster than one frame in a few clocks, so that each frame brings at most one rising edge. They also assume that `mode` stays steady while a reference is being tracked. The stimulus drives square-wave references with periods close to the frame length (one clock short, equal, one clock long, and a larger step). It switches mode or source only between phases, and it removes the reference entirely to exercise the loss path.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

  typedef enum logic [1:0] {
    CORR_NONE = 2'd0,
    CORR_UP   = 2'd1,
    CORR_DOWN = 2'd2
  } corr_e;

endpackage

// File: rtl/dpll_ref_sel.sv
module dpll_ref_sel #(
  parameter int NUM_REFS    = 3,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(NUM_REFS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_W-1:0]    mode,
  input  logic [NUM_REFS-1:0] refs,
  output logic                ref_edge
);

  logic [SYNC_STAGES-1:0] sync_q [NUM_REFS];
  logic                   sel;
  logic                   sel_prev_q;

  // one synchroniser chain per candidate input
  for (genvar g = 0; g < NUM_REFS; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) sync_q[g] <= '0;
      else        sync_q[g] <= {sync_q[g][SYNC_STAGES-2:0], refs[g]};
    end
  end

  // mode 0 selects nothing; mode k picks candidate k-1
  always_comb begin
    sel = 1'b0;
    for (int k = 0; k < NUM_REFS; k++) begin
      if (mode == SEL_W'(k + 1)) sel = sync_q[k][SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sel_prev_q <= 1'b0;
    else        sel_prev_q <= sel;
  end

  assign ref_edge = sel & ~sel_prev_q;

endmodule

// File: rtl/dpll_phase_cmp.sv
module dpll_phase_cmp
  import dpll_pkg::*;
#(
  parameter int FRAME_CLKS  = 2048,
  parameter int DEAD_BAND   = 1,
  parameter int MISS_FRAMES = 2,
  localparam int POS_W      = $clog2(2 * FRAME_CLKS),
  localparam int MISS_W     = $clog2(MISS_FRAMES + 2)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ref_edge,
  input  logic  frame_tick,
  input  logic  corr_take,
  output corr_e pend,
  output logic  lost
);

  localparam logic [POS_W-1:0]  POS_MAX  = {POS_W{1'b1}};
  localparam logic [POS_W-1:0]  HALF     = POS_W'(FRAME_CLKS / 2);
  localparam logic [POS_W-1:0]  DEAD     = POS_W'(DEAD_BAND);
  localparam logic [POS_W-1:0]  LATE_LIM = POS_W'(FRAME_CLKS - DEAD_BAND);
  localparam logic [MISS_W-1:0] MISS_LIM = MISS_W'(MISS_FRAMES);
  localparam logic [MISS_W-1:0] MISS_TOP = MISS_W'(MISS_FRAMES + 1);

  logic [POS_W-1:0]  since_q;
  logic [POS_W-1:0]  cur;
  logic [MISS_W-1:0] miss_q;
  corr_e             decide;
  corr_e             pend_q;

  // clocks elapsed since the most recent local tick (0 on the tick itself)
  always_comb begin
    if (frame_tick)            cur = '0;
    else if (since_q == POS_MAX) cur = since_q;
    else                       cur = since_q + POS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) since_q <= '0;
    else        since_q <= cur;
  end

  // early half of the frame: local tick led the reference -> retard
  // late half: reference leads the next local tick -> advance
  always_comb begin
    decide = CORR_NONE;
    if (cur <= HALF) begin
      if (cur > DEAD) decide = CORR_DOWN;
    end else if (cur < LATE_LIM) begin
      decide = CORR_UP;
    end
  end

  // frames without a reference edge; starts out lost
  always_ff @(posedge clk) begin
    if (!rst_n)                               miss_q <= MISS_TOP;
    else if (ref_edge)                        miss_q <= '0;
    else if (frame_tick && miss_q != MISS_TOP) miss_q <= miss_q + MISS_W'(1);
  end

  assign lost = (miss_q > MISS_LIM);

  always_ff @(posedge clk) begin
    if (!rst_n)        pend_q <= CORR_NONE;
    else if (lost)     pend_q <= CORR_NONE;
    else if (ref_edge) pend_q <= decide;
    else if (corr_take) pend_q <= CORR_NONE;
  end

  assign pend = pend_q;

endmodule

// File: rtl/dpll_divider.sv
module dpll_divider
  import dpll_pkg::*;
#(
  parameter int NOM_DIV   = 4,
  parameter int FRAME_DIV = 512,
  localparam int CNT_W    = $clog2(NOM_DIV + 2),
  localparam int EN_W     = $clog2(FRAME_DIV)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  corr_e pend,
  output logic  clk4_en,
  output logic  frame_tick,
  output logic  corr_take,
  output corr_e take_dir
);

  localparam logic [CNT_W-1:0] TC_NOM  = CNT_W'(NOM_DIV - 1);
  localparam logic [CNT_W-1:0] TC_UP   = CNT_W'(NOM_DIV - 2);
  localparam logic [CNT_W-1:0] TC_DOWN = CNT_W'(NOM_DIV);
  localparam logic [EN_W-1:0]  EN_LAST = EN_W'(FRAME_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tc_q;
  logic [CNT_W-1:0] tc_nxt;
  logic [EN_W-1:0]  en_cnt_q;
  logic             used_q;

  assign clk4_en    = (cnt_q == tc_q);
  assign frame_tick = clk4_en && (en_cnt_q == EN_LAST);

  // a divide cycle starting at a tick belongs to the new frame
  assign corr_take = clk4_en && (pend != CORR_NONE) && (!used_q || frame_tick);
  assign take_dir  = pend;

  always_comb begin
    tc_nxt = TC_NOM;
    if (corr_take) tc_nxt = (pend == CORR_UP) ? TC_UP : TC_DOWN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      tc_q     <= TC_NOM;
      en_cnt_q <= '0;
    end else if (clk4_en) begin
      cnt_q    <= '0;
      tc_q     <= tc_nxt;
      en_cnt_q <= frame_tick ? '0 : en_cnt_q + EN_W'(1);
    end else begin
      cnt_q    <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          used_q <= 1'b0;
    else if (corr_take)  used_q <= 1'b1;
    else if (frame_tick) used_q <= 1'b0;
  end

  AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    clk4_en |=> !clk4_en ##1 !clk4_en);  // R4

endmodule

// File: rtl/dpll_lock_mon.sv
module dpll_lock_mon
  import dpll_pkg::*;
#(
  parameter int LOCK_FRAMES = 16,
  parameter int UNLOCK_RUN  = 4,
  localparam int QW         = $clog2(LOCK_FRAMES + 1),
  localparam int RW         = $clog2(UNLOCK_RUN + 1)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  frame_tick,
  input  logic  corr_take,
  input  corr_e take_dir,
  input  logic  lost,
  output logic  locked
);

  localparam logic [QW-1:0] Q_LIM = QW'(LOCK_FRAMES);
  localparam logic [RW-1:0] R_LIM = RW'(UNLOCK_RUN);

  logic          seen_q;
  corr_e         dir_q;
  corr_e         prev_dir_q;
  logic [QW-1:0] quiet_q;
  logic [QW-1:0] quiet_nxt;
  logic [RW-1:0] run_q;
  logic [RW-1:0] run_nxt;
  logic          locked_q;

  always_comb begin
    quiet_nxt = (quiet_q == Q_LIM) ? quiet_q : quiet_q + QW'(1);
    if (run_q != '0 && dir_q == prev_dir_q)
      run_nxt = (run_q == R_LIM) ? run_q : run_q + RW'(1);
    else
      run_nxt = RW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || lost) begin
      seen_q     <= 1'b0;
      dir_q      <= CORR_NONE;
      prev_dir_q <= CORR_NONE;
      quiet_q    <= '0;
      run_q      <= '0;
      locked_q   <= 1'b0;
    end else begin
      if (corr_take)       seen_q <= 1'b1;
      else if (frame_tick) seen_q <= 1'b0;
      if (corr_take) dir_q <= take_dir;
      if (frame_tick) begin
        if (seen_q) begin
          quiet_q    <= '0;
          run_q      <= run_nxt;
          prev_dir_q <= dir_q;
          if (run_nxt >= R_LIM) locked_q <= 1'b0;
        end else begin
          run_q   <= '0;
          quiet_q <= quiet_nxt;
          if (quiet_nxt >= Q_LIM) locked_q <= 1'b1;
        end
      end
    end
  end

  assign locked = locked_q;

  AST_ONE_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    corr_take && !frame_tick && !lost |-> !seen_q);  // R4

  AST_LOCK_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(frame_tick));  // R7

endmodule

// File: rtl/dpll_8k.sv
module dpll_8k
  import dpll_pkg::*;
#(
  parameter int NOM_DIV     = 4,
  parameter int FRAME_DIV   = 512,
  parameter int DEAD_BAND   = 1,
  parameter int LOCK_FRAMES = 16,
  parameter int UNLOCK_RUN  = 4,
  parameter int MISS_FRAMES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       ref_a,
  input  logic       ref_b,
  input  logic       ref_c,
  output logic       clk4_en,
  output logic       frame_tick,
  output logic       locked
);

  localparam int FRAME_CLKS = NOM_DIV * FRAME_DIV;

  logic  ref_edge;
  logic  lost;
  logic  corr_take;
  corr_e pend;
  corr_e take_dir;

  dpll_ref_sel #(
    .NUM_REFS   (3),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .refs    ({ref_c, ref_b, ref_a}),
    .ref_edge(ref_edge)
  );

  dpll_phase_cmp #(
    .FRAME_CLKS (FRAME_CLKS),
    .DEAD_BAND  (DEAD_BAND),
    .MISS_FRAMES(MISS_FRAMES)
  ) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_edge  (ref_edge),
    .frame_tick(frame_tick),
    .corr_take (corr_take),
    .pend      (pend),
    .lost      (lost)
  );

  dpll_divider #(
    .NOM_DIV  (NOM_DIV),
    .FRAME_DIV(FRAME_DIV)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend),
    .clk4_en   (clk4_en),
    .frame_tick(frame_tick),
    .corr_take (corr_take),
    .take_dir  (take_dir)
  );

  dpll_lock_mon #(
    .LOCK_FRAMES(LOCK_FRAMES),
    .UNLOCK_RUN (UNLOCK_RUN)
  ) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_tick(frame_tick),
    .corr_take (corr_take),
    .take_dir  (take_dir),
    .lost      (lost),
    .locked    (locked)
  );

  AST_TICK_ON_EN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |-> clk4_en);  // R10

  AST_LOST_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> !locked);  // R9

  AST_FROZEN_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
    lost && $past(lost) && clk4_en |=> !clk4_en ##1 !clk4_en ##1 !clk4_en ##1 clk4_en);  // R9

endmodule

// File: tb/tb_dpll_8k.sv
module tb_dpll_8k;

  localparam int FDIV   = 32;
  localparam int FCLKS  = 4 * FDIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       ref_a, ref_b, ref_c;
  logic       clk4_en, frame_tick, locked;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  int ref_per   = 0;   // 0: reference held low
  int ref_route = 0;   // 0 none, 1 a, 2 b, 3 c
  int rcnt      = 0;
  logic refsig  = 1'b0;

  int    exp_q[$];     // expected enable intervals, 0 = any of 3..5
  string tag_q[$];
  bit    frame_chk = 0;
  int    last_en   = -1;
  int    nonnom    = 0;
  int    r10_left  = 8;

  always #2 clk = ~clk;

  dpll_8k #(.FRAME_DIV(FDIV)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
    .clk4_en(clk4_en), .frame_tick(frame_tick), .locked(locked)
  );

  assign ref_a = (ref_route == 1) ? refsig : 1'b0;
  assign ref_b = (ref_route == 2) ? refsig : 1'b0;
  assign ref_c = (ref_route == 3) ? refsig : 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // reference generator, driven away from the active edge
  always @(negedge clk) begin
    if (ref_per == 0) begin
      rcnt   = 0;
      refsig = 1'b0;
    end else begin
      rcnt   = (rcnt + 1 >= ref_per) ? 0 : rcnt + 1;
      refsig = (rcnt < ref_per / 2);
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      last_en = -1;
      nonnom  = 0;
    end else begin
      if (clk4_en) begin
        if (last_en >= 0) begin
          int intv;
          intv = cyc - last_en;
          if (intv != 4) nonnom++;
          if (exp_q.size() > 0) begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (e == 0) chk(intv >= 3 && intv <= 5, t, intv, 4);
            else        chk(intv == e, t, intv, e);
          end
        end
        last_en = cyc;
      end
      if (frame_tick) begin
        if (r10_left > 0) begin
          chk(clk4_en == 1'b1, "R10", clk4_en, 1);
          r10_left--;
        end
        if (frame_chk) chk(nonnom <= 1, "R4", nonnom, 1);
        nonnom = 0;
      end
    end
  end

  task automatic push_exp(input int n, input int v, input string t);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(v);
      tag_q.push_back(t);
    end
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic next_tick();
    @(negedge clk);
    while (!frame_tick) @(negedge clk);
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) next_tick();
  endtask

  task automatic tick_intv(input int n, input int exp, input string t);
    int prev;
    next_tick();
    prev = cyc;
    for (int i = 0; i < n; i++) begin
      next_tick();
      chk(cyc - prev == exp, t, cyc - prev, exp);
      prev = cyc;
    end
  endtask

  // counts ticks until locked reaches the wanted level, up to a limit
  task automatic wait_lock(input bit lvl, input int lim, output int n);
    n = 0;
    while (locked != lvl && n < lim) begin
      next_tick();
      n++;
    end
  endtask

  initial begin
    int n;
    // R1: reset state
    repeat (5) begin
      @(negedge clk);
      chk(clk4_en == 0 && frame_tick == 0 && locked == 0, "R1", {clk4_en, frame_tick, locked}, 0);
    end
    rst_n = 1'b1;
    @(negedge clk); chk(clk4_en == 0, "R1", clk4_en, 0);
    @(negedge clk); chk(clk4_en == 0, "R1", clk4_en, 0);
    @(negedge clk); chk(clk4_en == 1, "R1", clk4_en, 1);

    // R2: free run with no reference selected
    push_exp(3 * FDIV, 4, "R2");
    drain();
    tick_intv(2, FCLKS, "R2");
    chk(locked == 0, "R2", locked, 0);

    // R3: reference on an unselected pin is ignored
    mode = 2'd1; ref_route = 2; ref_per = FCLKS;
    wait_ticks(20);
    push_exp(2 * FDIV, 4, "R3");
    drain();
    chk(locked == 0, "R3", locked, 0);

    // R3/R7: selected pin locks, not before LOCK_FRAMES quiet frames
    ref_route = 1;
    wait_lock(1'b1, 140, n);
    chk(locked == 1, "R3", locked, 1);
    chk(n >= 16, "R7", n, 16);

    // R6: converged equal-period reference gives no corrections
    push_exp(4 * FDIV, 4, "R6");
    drain();
    tick_intv(3, FCLKS, "R6");
    chk(locked == 1, "R7", locked, 1);

    // R9: reference removed
    ref_route = 0;
    wait_ticks(5);
    chk(locked == 0, "R9", locked, 0);
    push_exp(2 * FDIV, 4, "R9");
    drain();
    tick_intv(2, FCLKS, "R9");

    // R8: lock again, then a large frequency step
    ref_route = 1;
    wait_lock(1'b1, 140, n);
    chk(locked == 1, "R7", locked, 1);
    frame_chk = 1;
    ref_per = FCLKS - 8;
    wait_lock(1'b0, 12, n);
    chk(locked == 0, "R8", locked, 0);
    chk(n >= 4, "R8", n, 4);

    // R5: faster reference on pin c
    mode = 2'd3; ref_route = 3; ref_per = FCLKS - 1;
    push_exp(20 * FDIV, 0, "R4");
    wait_ticks(90);
    tick_intv(6, FCLKS - 1, "R5");
    chk(locked == 0, "R8", locked, 0);

    // R5: slower reference
    ref_per = FCLKS + 1;
    wait_ticks(90);
    tick_intv(6, FCLKS + 1, "R5");
    drain();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule